// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller

This block gives software a bank of general-purpose I/O lines behind a small register bus. Each bus cycle is a single-cycle read or write strobe with a register index, a data word and one enable per byte lane. The number of lines equals the register width `W`, which may be 8, 16, 32 or 64. For every line the block drives an output value and an output enable, and it samples an input level. Input levels pass through a two-flop synchronizer before software can read them.

Software sets and clears lines in one of two ways. With the clear register built, it writes ones to an atomic set register or to a clear register. Without it, a write to the set register loads the whole output latch. Reading the set register returns the output latch, so the value driven on an output line can be read back instead of its pad level. The direction register can be built with either polarity, or left out so that every line is always driven. Two build options change the bus view of the lines. Mirrored order places line n at register bit W-1-n. Byte swapping reverses the byte lanes of 16-bit and 32-bit registers.

Top module: `gpio_mmio_ctrl`

Register indices on `bus_addr`: 0 is pin levels (read only), 1 is the set register, 2 is the clear register (write only), 3 is the direction register. All other indices are unmapped.

## Requirements
- R1: While reset is asserted and for two clock edges after `rst_n` rises, every line is an input and every output value is 0. The direction register then reads 0 in the build where 1 means output, and all ones in the build where 1 means input. `bus_rdata` reads 0 in this state.
- R2: A read of index 0 returns the synchronized pin levels, with 1 meaning high. A read strobe issued one cycle after a pin changes still returns the old level. A read strobe issued two cycles after the change returns the new level.
- R3: With the clear register built, writing 1 to a bit of index 1 drives that line high. Bits written as 0 leave their lines unchanged.
- R4: With the clear register built, writing 1 to a bit of index 2 drives that line low. Bits written as 0 leave their lines unchanged.
- R5: Without the clear register, a write to index 1 loads the output latch, so 1 drives high and 0 drives low. Index 2 is then unmapped.
- R6: A read of index 1 returns the output latch, which can differ from the pin levels on input lines.
- R7: In the build where 1 means output, a direction bit of 1 asserts `pin_oe` for that line and a 0 releases it.
- R8: In the build where 1 means input, a direction bit of 1 releases `pin_oe` and a 0 asserts it.
- R9: With no direction register built, `pin_oe` is all ones at all times and index 3 is unmapped.
- R10: With mirrored order, line n is at register bit W-1-n for writes and reads.
- R11: With byte swapping enabled and W of 16 or 32, bus byte lane k carries register byte W/8-1-k. With W of 8 or 64 the option has no effect. Combined with mirroring, bus bit 1 of a 16-bit word maps to line 6, and bus bit 8 maps to line 15.
- R12: `bus_be[k]` enables bus bits 8k+7..8k. For set and clear writes, disabled lanes act as zeros. For latch-load and direction writes, disabled lanes keep their old value.
- R13: Read data appears on `bus_rdata` the cycle after the read strobe and is 0 in every other cycle. Unmapped indices read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | AW | Register index |
| bus_wdata | input | W | Write data |
| bus_be | input | W/8 | Byte-lane write enables |
| bus_rdata | output | W | Read data, valid the cycle after `bus_rd` |
| pin_in | input | W | Sampled pad levels |
| pin_out | output | W | Output value per line |
| pin_oe | output | W | Output enable per line |

## Verification
A corrupted output latch or direction register shows at once on `pin_out` or `pin_oe`, one edge after the write that caused it. It also shows on the next read of index 1 or 3, one cycle after that strobe. A fault in the synchronizer or the lane mapping shows only through `bus_rdata`. It appears when index 0 is read two cycles or more after the pins settle, so the reference model is compared on every cycle against three builds with different width, polarity, order and byte-lane settings.

// File: rtl/gpio_mmio_pkg.sv
`timescale 1ns/1ps
package gpio_mmio_pkg;
  // Register indices on the bus
  localparam int IDX_PINS = 0;
  localparam int IDX_SET  = 1;
  localparam int IDX_CLR  = 2;
  localparam int IDX_DIR  = 3;

  // Direction register builds
  localparam int DIRM_NONE    = 0;
  localparam int DIRM_ONE_OUT = 1;
  localparam int DIRM_ONE_IN  = 2;

  typedef struct packed {
    logic pins;
    logic set;
    logic clr;
    logic dir;
  } reg_hit_t;
endpackage

// File: rtl/gpio_lane_map.sv
`timescale 1ns/1ps
// Maps between line order and bus bit order. The mapping is its own inverse,
// so the same module serves both directions.
module gpio_lane_map #(
  parameter int W      = 32,
  parameter int MIRROR = 0,
  parameter int SWAP   = 0
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  localparam int NB = W / 8;

  for (genvar n = 0; n < W; n++) begin : g_bit
    localparam int P = (MIRROR != 0) ? (W - 1 - n) : n;
    localparam int Q = (SWAP != 0) ? ((NB - 1 - P / 8) * 8 + P % 8) : P;
    assign dst[n] = src[Q];
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_regs.sv
`timescale 1ns/1ps
module gpio_out_regs
  import gpio_mmio_pkg::*;
#(
  parameter int W        = 32,
  parameter int HAS_CLR  = 1,
  parameter int DIR_MODE = DIRM_ONE_OUT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_set,
  input  logic         we_clr,
  input  logic         we_dir,
  input  logic [W-1:0] wval,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  localparam logic [W-1:0] DIR_RST = (DIR_MODE == DIRM_ONE_IN) ? '1 : '0;

  logic [W-1:0] latch_d;
  logic [W-1:0] dir_d;
  logic         latch_en;
  logic         dir_en;
  logic [W-1:0] hits;

  always_comb begin
    hits     = wval & wmask;
    latch_d  = latch_q;
    latch_en = 1'b0;
    if (we_set) begin
      latch_en = 1'b1;
      if (HAS_CLR != 0) latch_d = latch_q | hits;
      else              latch_d = (latch_q & ~wmask) | hits;
    end else if (we_clr) begin
      latch_en = 1'b1;
      latch_d  = latch_q & ~hits;
    end
  end

  always_comb begin
    dir_en = we_dir;
    dir_d  = (dir_q & ~wmask) | hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int W          = 32,
  parameter int AW         = 3,
  parameter int HAS_CLR    = 1,
  parameter int DIR_MODE   = DIRM_ONE_OUT,
  parameter int MIRROR     = 0,
  parameter int BIG_ENDIAN = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  input  logic [W/8-1:0] bus_be,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);
  localparam int NB   = W / 8;
  localparam int SWAP = ((BIG_ENDIAN != 0) && ((W == 16) || (W == 32))) ? 1 : 0;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Byte-lane enables expanded to a bit mask in bus order
  logic [W-1:0] bus_mask;
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign bus_mask[8*k +: 8] = {8{bus_be[k]}};
  end

  // Bus order to line order
  logic [W-1:0] wr_line;
  logic [W-1:0] mask_line;

  gpio_lane_map #(.W(W), .MIRROR(MIRROR), .SWAP(SWAP)) i_map_wdata (
    .src(bus_wdata), .dst(wr_line)
  );
  gpio_lane_map #(.W(W), .MIRROR(MIRROR), .SWAP(SWAP)) i_map_mask (
    .src(bus_mask), .dst(mask_line)
  );

  // Decode
  reg_hit_t hit;
  always_comb begin
    hit.pins = (bus_addr == AW'(IDX_PINS));
    hit.set  = (bus_addr == AW'(IDX_SET));
    hit.clr  = (HAS_CLR != 0) && (bus_addr == AW'(IDX_CLR));
    hit.dir  = (DIR_MODE != DIRM_NONE) && (bus_addr == AW'(IDX_DIR));
  end

  // Input synchronizer
  logic [W-1:0] pins_q;
  gpio_in_sync #(.W(W)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(pin_in), .sync_out(pins_q)
  );

  // Output latch and direction
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  gpio_out_regs #(.W(W), .HAS_CLR(HAS_CLR), .DIR_MODE(DIR_MODE)) i_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_set  (bus_wr && hit.set),
    .we_clr  (bus_wr && hit.clr),
    .we_dir  (bus_wr && hit.dir),
    .wval    (wr_line),
    .wmask   (mask_line),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  assign pin_out = latch_q;

  if (DIR_MODE == DIRM_ONE_OUT) begin : g_oe_high
    assign pin_oe = dir_q;
  end else if (DIR_MODE == DIRM_ONE_IN) begin : g_oe_low
    assign pin_oe = ~dir_q;
  end else begin : g_oe_fixed
    assign pin_oe = '1;
  end

  // Read path: select in line order, map to bus order, register
  logic [W-1:0] rd_line;
  logic [W-1:0] rd_bus;
  logic [W-1:0] rdata_d;

  always_comb begin
    rd_line = '0;
    if (hit.pins)     rd_line = pins_q;
    else if (hit.set) rd_line = latch_q;
    else if (hit.dir) rd_line = dir_q;
  end

  gpio_lane_map #(.W(W), .MIRROR(MIRROR), .SWAP(SWAP)) i_map_rdata (
    .src(rd_line), .dst(rd_bus)
  );

  always_comb rdata_d = bus_rd ? rd_bus : '0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bus_rdata <= '0;
    else            bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_mmio_ctrl_chk #(
  parameter int W        = 32,
  parameter int AW       = 3,
  parameter int HAS_CLR  = 1,
  parameter int DIR_MODE = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [W-1:0]   bus_rdata,
  input logic [W-1:0]   pin_out,
  input logic [W-1:0]   pin_oe
);
  logic wr_set;
  logic wr_clr;
  logic wr_dir;
  assign wr_set = bus_wr && (bus_addr == AW'(1));
  assign wr_clr = bus_wr && (bus_addr == AW'(2));
  assign wr_dir = bus_wr && (bus_addr == AW'(3));

  // R3: a set write with the clear register built never lowers a line
  a_r3_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((HAS_CLR != 0) && wr_set) |=> ((pin_out & $past(pin_out)) == $past(pin_out)));

  // R4: a clear write never raises a line
  a_r4_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out | $past(pin_out)) == $past(pin_out)));

  // R13: outputs change only through their own registers
  a_r13_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(pin_out));

  // R7: direction changes only on a direction write
  a_r7_dir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R13: read data is zero in cycles not following a read strobe
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(
  .W(W), .AW(AW), .HAS_CLR(HAS_CLR), .DIR_MODE(DIR_MODE)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_ref_model.sv
`timescale 1ns/1ps
// Behavioural cycle model of the controller; outputs expected port values.
module gpio_ref_model #(
  parameter int W          = 32,
  parameter int AW         = 3,
  parameter int HAS_CLR    = 1,
  parameter int DIR_MODE   = 1,
  parameter int MIRROR     = 0,
  parameter int BIG_ENDIAN = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           rd,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   ext,
  output logic [W-1:0]   exp_rdata,
  output logic [W-1:0]   exp_out,
  output logic [W-1:0]   exp_oe
);
  logic [W-1:0] latch, dir, s1, s2;
  int held;

  function automatic int bpos(int n);
    int p;
    p = (MIRROR != 0) ? (W - 1 - n) : n;
    if (BIG_ENDIAN != 0 && (W == 16 || W == 32)) p = (W/8 - 1 - p/8) * 8 + p % 8;
    return p;
  endfunction

  function automatic logic [W-1:0] to_line(logic [W-1:0] b);
    logic [W-1:0] l;
    for (int n = 0; n < W; n++) l[n] = b[bpos(n)];
    return l;
  endfunction

  function automatic logic [W-1:0] to_bus(logic [W-1:0] l);
    logic [W-1:0] b;
    for (int n = 0; n < W; n++) b[bpos(n)] = l[n];
    return b;
  endfunction

  function automatic logic [W-1:0] oe_of(logic [W-1:0] d);
    if (DIR_MODE == 0) return '1;
    if (DIR_MODE == 1) return d;
    return ~d;
  endfunction

  task automatic go_reset();
    latch = '0;
    dir = (DIR_MODE == 2) ? '1 : '0;
    s1 = '0; s2 = '0;
    exp_rdata = '0;
    exp_out = '0;
    exp_oe = oe_of(dir);
  endtask

  initial begin
    held = 0;
    go_reset();
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held = 0;
      go_reset();
    end else if (held < 2) begin
      held = held + 1;
    end else begin
      logic [W-1:0] pins, m, d, bm, rv;
      int a;
      for (int k = 0; k < W/8; k++) bm[8*k +: 8] = {8{be[k]}};
      pins = (oe_of(dir) & latch) | (~oe_of(dir) & ext);
      m = to_line(bm);
      d = to_line(wdata) & m;
      a = int'(addr);
      rv = '0;
      if (a == 0) rv = to_bus(s2);
      else if (a == 1) rv = to_bus(latch);
      else if (a == 3 && DIR_MODE != 0) rv = to_bus(dir);
      exp_rdata = rd ? rv : '0;
      s2 = s1;
      s1 = pins;
      if (wr) begin
        if (a == 1) latch = (HAS_CLR != 0) ? (latch | d) : ((latch & ~m) | d);
        else if (a == 2 && HAS_CLR != 0) latch = latch & ~d;
        else if (a == 3 && DIR_MODE != 0) dir = (dir & ~m) | d;
      end
      exp_out = latch;
      exp_oe = oe_of(dir);
    end
  end
endmodule

// File: tb/test_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_mmio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0] be = '0;
  logic [63:0] ext = '0;
  int sel = 0;
  int total = 0, bad = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  // Instance A: 32 lines, set/clear, 1 = output
  logic [31:0] rdata_a, out_a, oe_a, pin_a, xr_a, xo_a, xe_a;
  assign pin_a = (oe_a & out_a) | (~oe_a & ext[31:0]);
  gpio_mmio_ctrl #(.W(32), .AW(3), .HAS_CLR(1), .DIR_MODE(1), .MIRROR(0), .BIG_ENDIAN(0)) i_gpio_mmio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 0), .bus_rd(rd && sel == 0), .bus_addr(addr),
    .bus_wdata(wdata[31:0]), .bus_be(be[3:0]), .bus_rdata(rdata_a), .pin_in(pin_a),
    .pin_out(out_a), .pin_oe(oe_a));
  gpio_ref_model #(.W(32), .AW(3), .HAS_CLR(1), .DIR_MODE(1), .MIRROR(0), .BIG_ENDIAN(0)) i_ref_a (
    .clk(clk), .rst_n(rst_n), .wr(wr && sel == 0), .rd(rd && sel == 0), .addr(addr),
    .wdata(wdata[31:0]), .be(be[3:0]), .ext(ext[31:0]), .exp_rdata(xr_a), .exp_out(xo_a), .exp_oe(xe_a));

  // Instance B: 16 lines, load-only, 1 = input, mirrored, byte swapped
  logic [15:0] rdata_b, out_b, oe_b, pin_b, xr_b, xo_b, xe_b;
  assign pin_b = (oe_b & out_b) | (~oe_b & ext[15:0]);
  gpio_mmio_ctrl #(.W(16), .AW(3), .HAS_CLR(0), .DIR_MODE(2), .MIRROR(1), .BIG_ENDIAN(1)) i_gpio_mmio_ctrl_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 1), .bus_rd(rd && sel == 1), .bus_addr(addr),
    .bus_wdata(wdata[15:0]), .bus_be(be[1:0]), .bus_rdata(rdata_b), .pin_in(pin_b),
    .pin_out(out_b), .pin_oe(oe_b));
  gpio_ref_model #(.W(16), .AW(3), .HAS_CLR(0), .DIR_MODE(2), .MIRROR(1), .BIG_ENDIAN(1)) i_ref_b (
    .clk(clk), .rst_n(rst_n), .wr(wr && sel == 1), .rd(rd && sel == 1), .addr(addr),
    .wdata(wdata[15:0]), .be(be[1:0]), .ext(ext[15:0]), .exp_rdata(xr_b), .exp_out(xo_b), .exp_oe(xe_b));

  // Instance C: 8 lines, set/clear, no direction register
  logic [7:0] rdata_c, out_c, oe_c, pin_c, xr_c, xo_c, xe_c;
  assign pin_c = (oe_c & out_c) | (~oe_c & ext[7:0]);
  gpio_mmio_ctrl #(.W(8), .AW(3), .HAS_CLR(1), .DIR_MODE(0), .MIRROR(0), .BIG_ENDIAN(0)) i_gpio_mmio_ctrl_c (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 2), .bus_rd(rd && sel == 2), .bus_addr(addr),
    .bus_wdata(wdata[7:0]), .bus_be(be[0:0]), .bus_rdata(rdata_c), .pin_in(pin_c),
    .pin_out(out_c), .pin_oe(oe_c));
  gpio_ref_model #(.W(8), .AW(3), .HAS_CLR(1), .DIR_MODE(0), .MIRROR(0), .BIG_ENDIAN(0)) i_ref_c (
    .clk(clk), .rst_n(rst_n), .wr(wr && sel == 2), .rd(rd && sel == 2), .addr(addr),
    .wdata(wdata[7:0]), .be(be[0:0]), .ext(ext[7:0]), .exp_rdata(xr_c), .exp_out(xo_c), .exp_oe(xe_c));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rdat(int s);
    if (s == 0) return {32'b0, rdata_a};
    if (s == 1) return {48'b0, rdata_b};
    return {56'b0, rdata_c};
  endfunction

  task automatic do_wr(int s, int a, logic [63:0] d, logic [7:0] b);
    @(negedge clk);
    sel = s; wr = 1'b1; addr = 3'(a); wdata = d; be = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(int s, int a, output logic [63:0] v);
    @(negedge clk);
    sel = s; rd = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd = 1'b0;
    v = rdat(s);
  endtask

  // Cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R2 rdata A", {32'b0, rdata_a}, {32'b0, xr_a});
      chk("R3 out A",   {32'b0, out_a},   {32'b0, xo_a});
      chk("R7 oe A",    {32'b0, oe_a},    {32'b0, xe_a});
      chk("R11 rdata B", {48'b0, rdata_b}, {48'b0, xr_b});
      chk("R10 out B",   {48'b0, out_b},   {48'b0, xo_b});
      chk("R8 oe B",     {48'b0, oe_b},    {48'b0, xe_b});
      chk("R13 rdata C", {56'b0, rdata_c}, {56'b0, xr_c});
      chk("R4 out C",    {56'b0, out_c},   {56'b0, xo_c});
      chk("R9 oe C",     {56'b0, oe_c},    {56'b0, xe_c});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, v2, v3;
    @(negedge clk);
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 out A", {32'b0, out_a}, 64'h0);
    chk("R1 oe A", {32'b0, oe_a}, 64'h0);
    chk("R1 rdata A", {32'b0, rdata_a}, 64'h0);
    do_rd(0, 3, v); chk("R1 dir A", v, 64'h0);
    do_rd(0, 1, v); chk("R1 latch A", v, 64'h0);
    do_rd(1, 3, v); chk("R1 R8 dir B", v, 64'hFFFF);
    chk("R1 R8 oe B", {48'b0, oe_b}, 64'h0);

    // R2: pin level latency through the synchronizer
    @(negedge clk);
    ext = 64'hA5A5_0F0F; sel = 0; rd = 1'b1; addr = 3'd0;
    @(negedge clk); v = rdat(0);
    @(negedge clk); v2 = rdat(0);
    @(negedge clk); rd = 1'b0; v3 = rdat(0);
    chk("R2 one cycle after change", v2, 64'h0);
    chk("R2 two cycles after change", v3, 64'hA5A5_0F0F);
    @(negedge clk);
    chk("R13 idle rdata", rdat(0), 64'h0);

    // R3, R4: atomic set and clear
    do_wr(0, 1, 64'hF0, 8'hF); chk("R3 set F0", {32'b0, out_a}, 64'hF0);
    do_wr(0, 1, 64'h01, 8'hF); chk("R3 zeros keep", {32'b0, out_a}, 64'hF1);
    do_wr(0, 2, 64'h30, 8'hF); chk("R4 clear 30", {32'b0, out_a}, 64'hC1);

    // R6: latch readback differs from input pins
    do_rd(0, 1, v); chk("R6 latch read", v, 64'hC1);
    do_rd(0, 0, v); chk("R6 pins read", v, 64'hA5A5_0F0F);

    // R7: output-high direction
    do_wr(0, 3, 64'hFF, 8'hF); chk("R7 oe low byte", {32'b0, oe_a}, 64'hFF);
    repeat (3) @(negedge clk);
    do_rd(0, 0, v); chk("R7 driven pins read", v, 64'hA5A5_0FC1);

    // R12: byte enables
    do_wr(0, 1, 64'hFFFF_FFFF, 8'b0010); chk("R12 set lane1", {32'b0, out_a}, 64'hFFC1);
    do_wr(0, 3, 64'hFFFF_FFFF, 8'b1100); do_rd(0, 3, v); chk("R12 dir upper lanes", v, 64'hFFFF_00FF);
    do_wr(0, 2, 64'hFFFF_FFFF, 8'b0001); chk("R12 clear lane0", {32'b0, out_a}, 64'hFF00);

    // R13: unmapped index
    do_rd(0, 5, v); chk("R13 unmapped read", v, 64'h0);
    do_wr(0, 6, 64'hFFFF_FFFF, 8'hF);
    chk("R13 unmapped write out", {32'b0, out_a}, 64'hFF00);
    chk("R13 unmapped write oe", {32'b0, oe_a}, 64'hFFFF_00FF);

    // Instance B: load-only, input polarity, mirrored and swapped
    ext = 64'h0;
    do_wr(1, 1, 64'h0001, 8'h3); chk("R10 R11 bus bit0 to line7", {48'b0, out_b}, 64'h0080);
    do_wr(1, 1, 64'h0002, 8'h3); chk("R5 load replaces", {48'b0, out_b}, 64'h0040);
    do_wr(1, 2, 64'hFFFF, 8'h3); chk("R5 clear index unmapped", {48'b0, out_b}, 64'h0040);
    do_rd(1, 2, v); chk("R5 clear index reads zero", v, 64'h0);
    do_wr(1, 3, 64'h0000, 8'h3); chk("R8 zero means output", {48'b0, oe_b}, 64'hFFFF);
    repeat (3) @(negedge clk);
    do_rd(1, 0, v); chk("R10 pins read mapped", v, 64'h0002);
    do_wr(1, 1, 64'hFFFF, 8'b01); chk("R12 load lane0 only", {48'b0, out_b}, 64'h00FF);
    do_wr(1, 1, 64'h0100, 8'h3); chk("R11 bus bit8 to line15", {48'b0, out_b}, 64'h8000);

    // Instance C: no direction register
    chk("R9 oe all ones", {56'b0, oe_c}, 64'hFF);
    do_wr(2, 3, 64'h00, 8'h1); chk("R9 dir write ignored", {56'b0, oe_c}, 64'hFF);
    do_rd(2, 3, v); chk("R9 dir index reads zero", v, 64'h0);
    do_wr(2, 1, 64'h0F, 8'h1); do_wr(2, 2, 64'h03, 8'h1);
    chk("R4 8-bit set then clear", {56'b0, out_c}, 64'h0C);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule